// File: doc/BRIEF.md
# Two-Die Byte-Wide SRAM Sequencer

This block lets synchronous logic use a 1 MB byte-wide static memory built from two 512K x 8 asynchronous dies. The dies share one address bus, one data bus and one output-enable line. Each die has its own active-low chip enable and its own active-low write enable. The host side is a valid/ready request port with a 20-bit byte address, a write flag and write data. A one-cycle response strobe marks the end of each access and carries the read byte.

Address bit 19 picks the die, and bits 18:0 go out on the shared address bus. The block builds every memory strobe from its own state register. Each strobe phase lasts a whole number of clock cycles, and that number comes from the nanosecond limits divided by the clock-period parameter and rounded up. Back-pressure rule: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so the host must hold its request stable until that edge. The response port has no ready signal. `rsp_valid` is a single-cycle pulse that the host must take when it appears. The data bus is split into an output, a drive enable and an input, so the tri-state buffer can sit at the pad.

Top module: `sram_dual_die_ctrl`

## Requirements
- R1: During and right after reset, both chip enables and both write enables are high and the output enable is high. The data bus is not driven, `req_ready` is high and `rsp_valid` is low.
- R2: Request address bit 19 selects the die: 0 drives `mem_ce_n[0]` and 1 drives `mem_ce_n[1]`. Bits 18:0 appear on `mem_addr` and stay stable for as long as a chip enable is low.
- R3: A read holds the selected die's chip enable low and the output enable low, with both write enables high, for RD cycles. On the next edge the block samples `mem_dq_in` and raises `rsp_valid` for exactly one cycle, with the sampled byte on `rsp_rdata`.
- R4: A write holds the selected die's chip enable and write enable low for WP cycles, with the output enable high and `mem_dq_out` driven with the request data. Then the write enable rises while the chip enable stays low, and the data and address stay driven for HOLD cycles.
- R5: At most one chip enable is ever low, and the data bus is never driven while the output enable is low.
- R6: After a read's response cycle the output enable stays high and `req_ready` stays low for TURN cycles in total, counting the response cycle, before the next request can be taken.
- R7: A write ends with `rsp_valid` pulsed once as the recovery phase starts. All strobes are high and `req_ready` is low for REC cycles.
- R8: While the block is busy, `req_ready` is low. A request presented then causes no memory access and does not change memory contents.
- R9: Phase lengths are computed as ceil(ns / CLK_PERIOD_NS), with a minimum of 1: RD = max(access, cycle time), WP = max(pulse width, data setup, cycle time - HOLD), HOLD = max(data hold, address hold), TURN = output float time, REC = write-high time. At 10 ns these give RD=3, WP=2, HOLD=1, TURN=1, REC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address; bit 19 selects the die |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Byte from the last read |
| mem_addr | output | 19 | Shared die address |
| mem_ce_n | output | 2 | Per-die chip enable, active low |
| mem_we_n | output | 2 | Per-die write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
Directed accesses cover both ends of each die and the same low address on both dies. The same-address case separates correct die steering from address-only decoding. The memory model in the bench returns wrong data until the required number of access cycles has passed, so a read that samples early is caught. Write-then-read and read-then-write pairs exercise the bus turnaround. A request held during a busy access checks that it is ignored. Seeded random mixes of reads and writes to boundary-heavy addresses compare every read against a reference image and every strobe phase length against the computed counts.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_WR_REC
  } sdd_state_e;

  // whole cycles covering a time limit, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdd_die_strobes.sv
module sdd_die_strobes #(
  parameter int unsigned NUM_DIES = 2,
  parameter int unsigned SEL_W    = 1
) (
  input  logic [SEL_W-1:0]    die_sel,
  input  logic                ph_ce,
  input  logic                ph_we,
  output logic [NUM_DIES-1:0] ce_n,
  output logic [NUM_DIES-1:0] we_n
);

  for (genvar d = 0; d < NUM_DIES; d++) begin : g_die
    logic hit;
    assign hit     = (die_sel == SEL_W'(d));
    assign ce_n[d] = ~(ph_ce && hit);
    assign we_n[d] = ~(ph_we && hit);
  end

endmodule

// File: rtl/sdd_seq.sv
module sdd_seq
  import sdd_pkg::*;
#(
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned WP_CYC   = 2,
  parameter int unsigned HOLD_CYC = 1,
  parameter int unsigned REC_CYC  = 1,
  parameter int unsigned CNT_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic accept,
  output logic idle,
  output logic ph_ce,
  output logic ph_we,
  output logic ph_oe,
  output logic ph_drive,
  output logic capture,
  output logic done
);

  sdd_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;
  logic             done_q;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = last ? cnt_q : cnt_q - CNT_W'(1);
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req_valid) begin
          if (req_write) begin
            st_d  = ST_WR_PULSE;
            cnt_d = CNT_W'(WP_CYC - 1);
          end else begin
            st_d  = ST_RD_ACC;
            cnt_d = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD_ACC: if (last) begin
        st_d  = ST_RD_TURN;
        cnt_d = CNT_W'(TURN_CYC - 1);
      end
      ST_RD_TURN: if (last) st_d = ST_IDLE;
      ST_WR_PULSE: if (last) begin
        st_d  = ST_WR_HOLD;
        cnt_d = CNT_W'(HOLD_CYC - 1);
      end
      ST_WR_HOLD: if (last) begin
        st_d  = ST_WR_REC;
        cnt_d = CNT_W'(REC_CYC - 1);
      end
      ST_WR_REC: if (last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= last && (st_q == ST_RD_ACC || st_q == ST_WR_HOLD);
    end
  end

  assign idle     = (st_q == ST_IDLE);
  assign accept   = idle && req_valid;
  assign ph_ce    = (st_q == ST_RD_ACC) || (st_q == ST_WR_PULSE) || (st_q == ST_WR_HOLD);
  assign ph_we    = (st_q == ST_WR_PULSE);
  assign ph_oe    = (st_q == ST_RD_ACC);
  assign ph_drive = (st_q == ST_WR_PULSE) || (st_q == ST_WR_HOLD);
  assign capture  = (st_q == ST_RD_ACC) && last;
  assign done     = done_q;

  // R5
  drive_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_drive) |-> !$past(ph_oe));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/sram_dual_die_ctrl.sv
module sram_dual_die_ctrl
  import sdd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned DIE_ADDR_W    = 19,
  parameter int unsigned NUM_DIES      = 2,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned T_ACC_NS      = 25,
  parameter int unsigned T_CYCLE_NS    = 25,
  parameter int unsigned T_WP_NS       = 20,
  parameter int unsigned T_DSU_NS      = 15,
  parameter int unsigned T_DH_NS       = 2,
  parameter int unsigned T_AH_NS       = 2,
  parameter int unsigned T_WREC_NS     = 5,
  parameter int unsigned T_FLOAT_NS    = 10,
  localparam int unsigned SEL_W        = $clog2(NUM_DIES),
  localparam int unsigned ADDR_W       = DIE_ADDR_W + SEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [DIE_ADDR_W-1:0] mem_addr,
  output logic [NUM_DIES-1:0]   mem_ce_n,
  output logic [NUM_DIES-1:0]   mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in
);

  localparam int unsigned CYC_C    = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC = max2(ns_to_cyc(T_DH_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_AH_NS, CLK_PERIOD_NS));
  localparam int unsigned RD_CYC   = max2(ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS), CYC_C);
  localparam int unsigned WP_MIN   = max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_DSU_NS, CLK_PERIOD_NS));
  localparam int unsigned WP_CYC   = max2(WP_MIN, (CYC_C > HOLD_CYC) ? CYC_C - HOLD_CYC : 1);
  localparam int unsigned TURN_CYC = ns_to_cyc(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC  = ns_to_cyc(T_WREC_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_MAX  = max2(max2(RD_CYC, WP_CYC), max2(max2(TURN_CYC, REC_CYC), HOLD_CYC));
  localparam int unsigned CNT_W    = $clog2(CNT_MAX) + 1;

  logic accept, idle, ph_ce, ph_we, ph_oe, ph_drive, capture, done;

  logic [DIE_ADDR_W-1:0] addr_q;
  logic [SEL_W-1:0]      die_q;
  logic [DATA_W-1:0]     wdata_q;
  logic [DATA_W-1:0]     rdata_q;

  sdd_seq #(
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .WP_CYC  (WP_CYC),
    .HOLD_CYC(HOLD_CYC),
    .REC_CYC (REC_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .accept   (accept),
    .idle     (idle),
    .ph_ce    (ph_ce),
    .ph_we    (ph_we),
    .ph_oe    (ph_oe),
    .ph_drive (ph_drive),
    .capture  (capture),
    .done     (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      die_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr[DIE_ADDR_W-1:0];
        die_q   <= req_addr[ADDR_W-1 -: SEL_W];
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= mem_dq_in;
    end
  end

  sdd_die_strobes #(
    .NUM_DIES(NUM_DIES),
    .SEL_W   (SEL_W)
  ) u_strobes (
    .die_sel(die_q),
    .ph_ce  (ph_ce),
    .ph_we  (ph_we),
    .ce_n   (mem_ce_n),
    .we_n   (mem_we_n)
  );

  assign req_ready  = idle;
  assign rsp_valid  = done;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_oe_n   = ~ph_oe;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = ph_drive;

  // R5
  one_die_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_ce_n) <= 1);

  // R5
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R4
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_we_n) & mem_ce_n) == '0);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(~mem_ce_n)) && $past(|(~mem_ce_n))) |-> $stable(mem_addr));

  // R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&mem_ce_n) && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sram_dual_die_ctrl_tb.sv
module sram_dual_die_ctrl_tb;

  localparam int PER = 10;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int HOLD_E = (cyc(2) > cyc(2)) ? cyc(2) : cyc(2);
  localparam int RD_E   = (cyc(25) > cyc(25)) ? cyc(25) : cyc(25);
  localparam int WPA    = (cyc(20) > cyc(15)) ? cyc(20) : cyc(15);
  localparam int WP_E   = (WPA > cyc(25) - HOLD_E) ? WPA : cyc(25) - HOLD_E;
  localparam int TURN_E = cyc(10);
  localparam int REC_E  = cyc(5);
  localparam int ACC_E  = cyc(25);

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic [1:0]  mem_ce_n, mem_we_n;
  logic        mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  int n_tests = 0, n_fail = 0;
  int bus_viol = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  sram_dual_die_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // ---------- memory model and reference image ----------
  logic [7:0] mdl [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] init_val(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction
  function automatic logic [7:0] mdl_val(input logic [19:0] a);
    return mdl.exists(int'(a)) ? mdl[int'(a)] : init_val(a);
  endfunction
  function automatic logic [7:0] ref_val(input logic [19:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
  endfunction

  int          rd_cnt = 0;
  logic [19:0] rd_key = '0;
  bit          wr_prev = 0;
  logic [19:0] wr_key = '0;
  logic [7:0]  wr_dat = '0;

  always @(negedge clk) begin
    logic [19:0] key;
    key = {mem_ce_n[0], mem_addr};
    if ($countones(~mem_ce_n) > 1 || (mem_dq_oe && !mem_oe_n)) bus_viol++;
    if (!mem_oe_n && mem_we_n == 2'b11 && $countones(~mem_ce_n) == 1) begin
      rd_cnt = (key == rd_key) ? rd_cnt + 1 : 1;
      rd_key = key;
      mem_dq_in <= (rd_cnt >= ACC_E) ? mdl_val(key) : ~mdl_val(key);
    end else begin
      rd_cnt = 0;
      mem_dq_in <= 8'h00;
    end
    if (mem_we_n != 2'b11) begin
      wr_prev = 1;
      wr_key  = {mem_we_n[0], mem_addr};
      wr_dat  = mem_dq_oe ? mem_dq_out : 8'hxx;
    end else if (wr_prev) begin
      wr_prev = 0;
      mdl[int'(wr_key)] = wr_dat;
    end
  end

  // ---------- checking helpers ----------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  function automatic bit sel_ok(input logic [19:0] a);
    return mem_ce_n == (a[19] ? 2'b01 : 2'b10) && mem_addr == a[18:0];
  endfunction

  task automatic do_read(input logic [19:0] a, input bit poke);
    logic [7:0] exp;
    int lat, n;
    bit busy_ok;
    exp = ref_val(a);
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = $urandom;
    @(negedge clk);
    // R2 R3: strobes of the selected die in the first access cycle
    check(sel_ok(a) && !mem_oe_n && mem_we_n == 2'b11, "R2/R3 read strobes",
          {mem_ce_n, mem_we_n, mem_oe_n}, {(a[19] ? 2'b01 : 2'b10), 2'b11, 1'b0});
    busy_ok = 1;
    if (poke) begin
      // R8: a write held during the busy read must be ignored
      req_write = 1; req_addr = a ^ 20'h00001; req_wdata = ~ref_val(a ^ 20'h00001);
      busy_ok = !req_ready;
      @(negedge clk);
      busy_ok = busy_ok && !req_ready && mem_we_n == 2'b11;
      check(busy_ok, "R8 busy ignores request", req_ready, 0);
      lat = 2;
    end else lat = 1;
    req_valid = 0;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    // R3 R9: response RD cycles after acceptance plus the sample edge
    check(lat == RD_E + 1, "R3/R9 read latency", lat, RD_E + 1);
    check(rsp_rdata == exp, "R3 read data", rsp_rdata, exp);
    // R6: output enable released, response pulse then ready after TURN cycles
    check(mem_oe_n && mem_ce_n == 2'b11 && !req_ready, "R6 bus released", {mem_oe_n, mem_ce_n}, 3'b111);
    n = 0;
    while (!req_ready && n < 50) begin n++; @(negedge clk); end
    check(n == TURN_E, "R6 turnaround cycles", n, TURN_E);
    check(!rsp_valid, "R3 done single cycle", rsp_valid, 0);
  endtask

  task automatic do_write(input logic [19:0] a, input logic [7:0] d);
    int wl, hl, guard, n;
    bit ok;
    wait_ready();
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_wdata = ~d;
    wl = 0; hl = 0; ok = 1; guard = 0;
    while (!rsp_valid && guard < 50) begin
      guard++;
      if (mem_we_n != 2'b11) begin
        wl++;
        ok = ok && sel_ok(a) && mem_we_n == mem_ce_n && mem_oe_n && mem_dq_oe && mem_dq_out == d;
      end else if (mem_ce_n != 2'b11) begin
        hl++;
        ok = ok && sel_ok(a) && mem_dq_oe && mem_dq_out == d;
      end
      @(negedge clk);
    end
    check(ok, "R2/R4 write strobes and data", {mem_ce_n, mem_dq_out}, {(a[19] ? 2'b01 : 2'b10), d});
    check(wl == WP_E, "R4/R9 write pulse cycles", wl, WP_E);
    check(hl == HOLD_E, "R4/R9 write hold cycles", hl, HOLD_E);
    // R7: recovery with all strobes high
    check(mem_ce_n == 2'b11 && mem_we_n == 2'b11 && !mem_dq_oe && !req_ready, "R7 recovery strobes",
          {mem_ce_n, mem_we_n, mem_dq_oe}, 5'b11110);
    n = 0;
    while (!req_ready && n < 50) begin n++; @(negedge clk); end
    check(n == REC_E, "R7 recovery cycles", n, REC_E);
    ref_mem[int'(a)] = d;
  endtask

  function automatic logic [19:0] rand_addr();
    logic [18:0] lo;
    lo = ($urandom % 2) ? 19'h7FFFF - 19'($urandom % 4) : 19'($urandom % 4);
    return {1'($urandom % 2), lo};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check(mem_ce_n == 2'b11 && mem_we_n == 2'b11 && mem_oe_n && !mem_dq_oe && !rsp_valid,
          "R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b111110);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && mem_ce_n == 2'b11 && mem_oe_n, "R1 after reset", {req_ready, rsp_valid}, 2'b10);

    // R2: same low address on both dies holds separate bytes
    do_write(20'h00123, 8'hAA);
    do_write(20'h80123, 8'h55);
    do_read(20'h00123, 0);
    do_read(20'h80123, 0);
    // boundaries of each die
    do_write(20'h7FFFF, 8'h3C);
    do_write(20'h80000, 8'hC3);
    do_read(20'h7FFFF, 0);
    do_read(20'h80000, 0);
    do_read(20'hFFFFF, 0);
    do_read(20'h00000, 0);
    // R8: poke during a busy read, then confirm the poked byte kept its value
    do_read(20'h00123, 1);
    do_read(20'h00122, 0);
    // read then write back to back on the same location (R6 turnaround)
    do_read(20'h80123, 0);
    do_write(20'h80123, 8'h0F);
    do_read(20'h80123, 0);

    for (int i = 0; i < 80; i++) begin
      logic [19:0] a;
      a = rand_addr();
      if ($urandom % 2) do_write(a, 8'($urandom));
      else do_read(a, 0);
    end

    // R5: shared-bus rules over the whole run
    check(bus_viol == 0, "R5 bus exclusivity", bus_viol, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule